// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from the moment an exception or a reset is accepted to the moment the handler's first instruction can be fetched. A request arrives with a vector number, a flag that says whether it is a reset, the current program counter, condition-code byte and stack pointer, and a mode bit. The mode bit selects a 64 KB address mode or a 16 MB address mode. For an ordinary exception the sequencer first saves the return state on the stack with one 32-bit write. It then reads the handler address from the vector table and produces the new program counter, the new condition-code byte and the new stack pointer. A reset skips the stack write, because the stack pointer cannot be trusted at that point.

Memory is reached through a single request/acknowledge port. The sequencer holds its request and the qualifiers of the access steady until the acknowledge arrives, and it never has more than one access outstanding. Once the handler address is loaded, a one-cycle done pulse tells the core that it may resume fetching. While a sequence is in flight the block takes no further requests. Deciding which request wins is left to the requester.

Top module: `exc_entry_seq`

## Requirements
- R1: In 64 KB mode (wideMode=0) the vector read goes to byte address 2×n with memSize=0 (16-bit). The new PC is read data bits 15:0 with bit 0 forced to 0 and bits 23:16 cleared.
- R2: In 16 MB mode (wideMode=1) the vector read goes to byte address 4×n with memSize=1 (32-bit). Read data bits 31:24 are ignored, and the new PC is bits 23:0 with bit 0 forced to 0.
- R3: From the cycle after a request is accepted, ccrOut equals the incoming condition byte with bit 7 (interrupt mask) set and every other bit kept. This holds for resets as well.
- R4: A reset request (reqIsReset=1) performs no memory write and always reads entry 0, whatever reqVector holds. spOut then equals spIn unchanged.
- R5: In 64 KB mode an exception makes one write (memWrite=1, memSize=1) to (spIn−4) mod 2^16. The data is {ccr, ccr, pc[15:0]}, where ccr is the byte before masking, and spOut becomes that address.
- R6: In 16 MB mode an exception makes one write to (spIn−4) mod 2^24 with data {ccr, pc[23:0]}, where ccr is the byte before masking, and spOut becomes that address.
- R7: memReq, memAddr and memWrite stay unchanged until memAck is seen. The stack write completes before the vector read is requested.
- R8: done is high for exactly one cycle, in the cycle after the vector read is acknowledged, and pcOut already holds the new PC in that cycle.
- R9: A request presented while busy is ignored. A request still held in the cycle after done is accepted then.
- R10: After reset the block is idle: busy, done and memReq are 0, and pcOut, ccrOut and spOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Exception or reset entry request |
| reqIsReset | input | 1 | The request is a reset (no stack write, entry 0) |
| reqVector | input | 8 | Vector number |
| wideMode | input | 1 | 1 = 16 MB mode, 0 = 64 KB mode |
| pcIn | input | 24 | Return program counter |
| ccrIn | input | 8 | Condition-code byte before entry |
| spIn | input | 24 | Stack pointer before entry |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memSize | output | 1 | 1 = 32-bit, 0 = 16-bit access |
| memAddr | output | 24 | Byte address |
| memWdata | output | 32 | Write data (stack frame) |
| memRdata | input | 32 | Read data (vector entry) |
| memAck | input | 1 | Access complete |
| pcOut | output | 24 | Handler program counter |
| ccrOut | output | 8 | Condition-code byte with mask set |
| spOut | output | 24 | Stack pointer after entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The acceptance of a new request and the end of the previous sequence can fall in the same cycle. A requester that keeps reqValid high sees its request taken in the idle cycle right after done. One test keeps reqValid asserted with different parameters across a whole sequence. It then checks that the reads and writes seen by the memory model all belong to the first request, that the done pulse lasts one cycle, and that the held request starts a second, separate sequence whose own addresses and results are checked. The memory model also stretches acknowledges by several cycles so that request stability across wait states is exercised.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_PUSH,
    S_FETCH,
    S_DONE
  } seqState_t;

  typedef struct packed {
    logic latch;     // capture request context
    logic fetchSel;  // address the vector table instead of the stack
    logic loadPc;    // take handler address from read data
  } seqStrobe_t;
endpackage

// File: rtl/exc_seq_ctl.sv
module exc_seq_ctl
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsReset,
  input  logic       memAck,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       memWrite,
  output logic       busy,
  output logic       done
);
  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.latch = 1'b1;
          stateNext    = reqIsReset ? S_FETCH : S_PUSH;
        end
      end
      S_PUSH: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) stateNext = S_FETCH;
      end
      S_FETCH: begin
        memReq          = 1'b1;
        strobe.fetchSel = 1'b1;
        if (memAck) begin
          strobe.loadPc = 1'b1;
          stateNext     = S_DONE;
        end
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int VEC_W       = 8,
  parameter int CCR_W       = 8,
  parameter int NARROW_W    = 16,
  parameter int MASK_BIT    = 7,
  parameter int FRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqIsReset,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [CCR_W-1:0]  ccrIn,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [CCR_W-1:0]  ccrOut,
  output logic [ADDR_W-1:0] spOut
);
  localparam logic [ADDR_W-1:0] NARROW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [ADDR_W-1:0] EVEN_MASK   = ~ADDR_W'(1);
  localparam logic [CCR_W-1:0]  CCR_SETMASK = CCR_W'(1) << MASK_BIT;

  logic              wideQ;
  logic [VEC_W-1:0]  vecQ;
  logic [ADDR_W-1:0] pcQ, spQ;
  logic [CCR_W-1:0]  ccrQ;
  logic [DATA_W-1:0] frameQ;

  logic [ADDR_W-1:0] spDec, spNext, vecAddr, pcFetched;
  logic [DATA_W-1:0] frameNext;
  logic              unusedRdTop;

  assign spDec  = spIn - ADDR_W'(FRAME_BYTES);
  assign spNext = reqIsReset ? spIn : (wideMode ? spDec : (spDec & NARROW_MASK));

  // frame layout and vector spacing depend on the address mode
  assign frameNext = wideMode ? DATA_W'({ccrIn, pcIn})
                              : DATA_W'({ccrIn, ccrIn, pcIn[NARROW_W-1:0]});
  assign vecAddr   = wideQ ? (ADDR_W'(vecQ) << 2) : (ADDR_W'(vecQ) << 1);
  assign pcFetched = (wideQ ? memRdata[ADDR_W-1:0]
                            : (memRdata[ADDR_W-1:0] & NARROW_MASK)) & EVEN_MASK;
  assign unusedRdTop = ^memRdata[DATA_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideQ  <= 1'b0;
      vecQ   <= '0;
      pcQ    <= '0;
      spQ    <= '0;
      ccrQ   <= '0;
      frameQ <= '0;
    end else begin
      if (strobe.latch) begin
        wideQ  <= wideMode;
        vecQ   <= reqIsReset ? '0 : reqVector;
        ccrQ   <= ccrIn | CCR_SETMASK;
        spQ    <= spNext;
        frameQ <= frameNext;
      end
      if (strobe.loadPc) pcQ <= pcFetched;
    end
  end

  assign memAddr  = strobe.fetchSel ? vecAddr : spQ;
  assign memSize  = strobe.fetchSel ? wideQ : 1'b1;
  assign memWdata = frameQ;
  assign pcOut    = pcQ;
  assign ccrOut   = ccrQ;
  assign spOut    = spQ;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int CCR_W    = 8,
  parameter int NARROW_W = 16,
  parameter int MASK_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsReset,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic              wideMode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [CCR_W-1:0]  ccrIn,
  input  logic [ADDR_W-1:0] spIn,
  output logic              memReq,
  output logic              memWrite,
  output logic              memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [ADDR_W-1:0] pcOut,
  output logic [CCR_W-1:0]  ccrOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              busy,
  output logic              done
);
  seqStrobe_t strobe;

  exc_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsReset(reqIsReset),
    .memAck(memAck), .strobe(strobe), .memReq(memReq), .memWrite(memWrite),
    .busy(busy), .done(done)
  );

  exc_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .CCR_W(CCR_W),
    .NARROW_W(NARROW_W), .MASK_BIT(MASK_BIT), .FRAME_BYTES(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqIsReset(reqIsReset),
    .reqVector(reqVector), .wideMode(wideMode), .pcIn(pcIn), .ccrIn(ccrIn),
    .spIn(spIn), .memRdata(memRdata), .memSize(memSize), .memAddr(memAddr),
    .memWdata(memWdata), .pcOut(pcOut), .ccrOut(ccrOut), .spOut(spOut)
  );
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int ADDR_W   = 24,
  parameter int VEC_W    = 8,
  parameter int CCR_W    = 8,
  parameter int MASK_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWrite,
  input logic              memSize,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic [ADDR_W-1:0] pcOut,
  input logic [CCR_W-1:0]  ccrOut,
  input logic              busy,
  input logic              done
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_pc_even_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !pcOut[0]));

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  p_push_then_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite && memAck) |=> (memReq && !memWrite));

  p_mask_while_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ccrOut[MASK_BIT]);

  p_narrow_vec_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && !memSize) |->
      (!memAddr[0] && (memAddr[ADDR_W-1:VEC_W+1] == '0)));

  p_wide_vec_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWrite && memSize) |->
      ((memAddr[1:0] == 2'b00) && (memAddr[ADDR_W-1:VEC_W+2] == '0)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !done));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .CCR_W(CCR_W), .MASK_BIT(MASK_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWrite(memWrite),
  .memSize(memSize), .memAddr(memAddr), .memAck(memAck), .pcOut(pcOut),
  .ccrOut(ccrOut), .busy(busy), .done(done)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  typedef struct packed {
    logic        wide;
    logic        rst;
    logic [7:0]  vec;
    logic [23:0] pc;
    logic [7:0]  ccr;
    logic [23:0] sp;
    logic [1:0]  waitN;
  } vec_t;

  localparam vec_t TV [6] = '{
    '{1'b0, 1'b0, 8'h05, 24'h001234, 8'h05, 24'h00FF00, 2'd0},
    '{1'b1, 1'b0, 8'h1C, 24'hABCDEF, 8'h2A, 24'h00FFF0, 2'd2},
    '{1'b0, 1'b1, 8'h33, 24'h000000, 8'h00, 24'h007777, 2'd1},
    '{1'b1, 1'b1, 8'h07, 24'h000000, 8'h41, 24'h123456, 2'd0},
    '{1'b0, 1'b0, 8'hFF, 24'h12FFFE, 8'h80, 24'h000002, 2'd3},
    '{1'b1, 1'b0, 8'h00, 24'h000100, 8'hC5, 24'h000000, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqIsReset = 1'b0, wideMode = 1'b0;
  logic [7:0]  reqVector = '0;
  logic [23:0] pcIn = '0, spIn = '0;
  logic [7:0]  ccrIn = '0;
  logic        memReq, memWrite, memSize, busy, done;
  logic [23:0] memAddr, pcOut, spOut;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic [7:0]  ccrOut;

  int checks = 0, fails = 0;
  int waitN = 0, cnt = 0;
  int wrCnt = 0, rdCnt = 0, accCnt = 0, wrIdx = 0, rdIdx = 0;
  logic [23:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdSize = 1'b0;

  always #2 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsReset(reqIsReset),
    .reqVector(reqVector), .wideMode(wideMode), .pcIn(pcIn), .ccrIn(ccrIn),
    .spIn(spIn), .memReq(memReq), .memWrite(memWrite), .memSize(memSize),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .pcOut(pcOut), .ccrOut(ccrOut), .spOut(spOut), .busy(busy), .done(done)
  );

  function automatic logic [31:0] memVal(input logic [23:0] a);
    logic [23:0] low;
    low = a * 24'd3 + 24'h12345;
    return {8'hEE, low};
  endfunction

  // memory model: acknowledges after waitN extra cycles, records accesses
  always @(negedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      cnt    <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
      cnt    <= 0;
    end else if (memReq) begin
      if (cnt >= waitN) begin
        memAck <= 1'b1;
        accCnt <= accCnt + 1;
        if (memWrite) begin
          wrCnt  <= wrCnt + 1;
          wrAddr <= memAddr;
          wrData <= memWdata;
          wrIdx  <= accCnt;
        end else begin
          rdCnt    <= rdCnt + 1;
          rdAddr   <= memAddr;
          rdSize   <= memSize;
          rdIdx    <= accCnt;
          memRdata <= memVal(memAddr);
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic driveReq(input vec_t t);
    wideMode = t.wide; reqIsReset = t.rst; reqVector = t.vec;
    pcIn = t.pc; ccrIn = t.ccr; spIn = t.sp; reqValid = 1'b1;
  endtask

  // checks one finished sequence against values derived from the requirements
  task automatic checkResult(input vec_t t, input int wb, input int rb);
    logic [23:0] eVa, ePc, eSp;
    logic [31:0] m, eW;
    eVa = t.rst ? 24'h0 : (t.wide ? 24'(t.vec) * 24'd4 : 24'(t.vec) * 24'd2);
    m   = memVal(eVa);
    ePc = t.wide ? {m[23:1], 1'b0} : {8'h00, m[15:1], 1'b0};
    eSp = t.rst ? t.sp : (t.wide ? t.sp - 24'd4 : {8'h00, 16'(t.sp - 24'd4)});
    eW  = t.wide ? {t.ccr, t.pc} : {t.ccr, t.ccr, t.pc[15:0]};
    if (t.wide) begin
      chk(pcOut == ePc, "R2 pc", 32'(pcOut), 32'(ePc));
      chk(rdAddr == eVa && rdSize == 1'b1, "R2 vector addr/size", {rdSize, 7'h0, rdAddr}, {8'h80, eVa});
    end else begin
      chk(pcOut == ePc, "R1 pc", 32'(pcOut), 32'(ePc));
      chk(rdAddr == eVa && rdSize == 1'b0, "R1 vector addr/size", {rdSize, 7'h0, rdAddr}, {8'h00, eVa});
    end
    chk(rdCnt - rb == 1, "R8 one vector read", 32'(rdCnt - rb), 32'd1);
    if (t.rst) begin
      chk(wrCnt == wb, "R4 no push on reset", 32'(wrCnt - wb), 32'd0);
      chk(spOut == eSp, "R4 sp unchanged", 32'(spOut), 32'(eSp));
    end else begin
      chk(wrCnt - wb == 1, "R5 R6 one push", 32'(wrCnt - wb), 32'd1);
      chk(wrAddr == eSp && spOut == eSp, t.wide ? "R6 push addr" : "R5 push addr", 32'(wrAddr), 32'(eSp));
      chk(wrData == eW, t.wide ? "R6 frame" : "R5 frame", wrData, eW);
      chk(rdIdx > wrIdx, "R7 push before fetch", 32'(rdIdx), 32'(wrIdx + 1));
    end
  endtask

  task automatic runEntry(input vec_t t);
    int wb, rb;
    bit ok;
    wb = wrCnt; rb = rdCnt; waitN = int'(t.waitN);
    @(negedge clk);
    driveReq(t);
    @(negedge clk);
    reqValid = 1'b0;
    chk(ccrOut == (t.ccr | 8'h80), "R3 mask set", 32'(ccrOut), 32'(t.ccr | 8'h80));
    waitDone(ok);
    chk(ok, "R8 done seen", 32'(ok), 32'd1);
    checkResult(t, wb, rb);
    @(negedge clk);
    chk(!done, "R8 single-cycle done", 32'(done), 32'd0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    int wb, rb;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReq, "R10 idle after reset", {29'h0, busy, done, memReq}, 32'h0);
    chk(pcOut == 0 && ccrOut == 0 && spOut == 0, "R10 outputs cleared", 32'(pcOut), 32'h0);

    for (int i = 0; i < 6; i++) runEntry(TV[i]);

    // R9: other requests presented while busy must be ignored
    wb = wrCnt; rb = rdCnt; waitN = 3;
    @(negedge clk);
    driveReq(TV[0]);
    @(negedge clk);
    driveReq(TV[3]);
    waitDone(ok);
    reqValid = 1'b0;
    chk(ok, "R9 done seen", 32'(ok), 32'd1);
    checkResult(TV[0], wb, rb);
    @(negedge clk);
    @(negedge clk);
    chk(!busy && rdCnt - rb == 1, "R9 busy request dropped", 32'(rdCnt - rb), 32'd1);

    // R9: a request held through done starts a new sequence in the idle cycle
    wb = wrCnt; rb = rdCnt; waitN = 1;
    @(negedge clk);
    driveReq(TV[1]);
    @(negedge clk);
    waitDone(ok);
    chk(ok, "R9 first done", 32'(ok), 32'd1);
    checkResult(TV[1], wb, rb);
    @(negedge clk);
    chk(!busy && !done, "R9 idle cycle after done", {30'h0, busy, done}, 32'h0);
    driveReq(TV[5]);
    wb = wrCnt; rb = rdCnt;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R9 held request accepted", 32'(busy), 32'd1);
    waitDone(ok);
    chk(ok, "R9 second done", 32'(ok), 32'd1);
    checkResult(TV[5], wb, rb);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule